// File: doc/BRIEF.md
# Reset Cause and Soft-Reset Control Register

This block keeps a single 32-bit status and control word that tells software why the system last came out of reset, and lets software ask for a new reset. Only the top five bits of the word are implemented. Three of them are cause flags that software clears by writing 1. The other two are request flags that a write of 1 sets. Writing either request flag produces a one-cycle reset request pulse toward the system reset sequencer.

The block counts the system resets it sees on `sys_rst_evt_i`, which the sequencer pulses for one cycle per reset. When that count is still zero at a reset event, the reset is treated as a power-on and the word is loaded with only the power-on flag set. Any later reset leaves the word as it is. A soft power-on request clears the count, so the reset it triggers is again recorded as a power-on. The active-low `rst_n` input is the power-on reset of the block itself.

Register accesses use a simple one-cycle strobe port. Writes take effect at the clock edge. Read data is combinational and is valid in the same cycle as the strobe. There is no back-pressure: every access completes at once.

Top module: `rst_cause_ctl`

## Requirements
- R1: Bits 26 to 0 of the word always read 0, and writing 1 to them has no effect. The implemented mask is 0xF8000000.
- R2: Bits 31 (power-on), 28 and 27 (button causes) are write-1-to-clear. Writing 0 to them leaves them unchanged.
- R3: Bits 30 (soft power-on request) and 29 (soft external reset request) are set by writing 1. Writing 0 to them leaves them unchanged.
- R4: A write with bit 30 or bit 29 set drives `rst_req_o` high in the cycle after the write edge, for exactly one cycle. No other access drives it high.
- R5: A write with bit 30 set clears the reset counter, so the next reset event is recorded as a power-on. A write with only bit 29 set leaves the counter unchanged.
- R6: A reset event while the counter is zero loads the word with 0x80000000.
- R7: A reset event while the counter is nonzero leaves the word unchanged.
- R8: The register is selected when address bits [15:3] equal those of `BASE` (0xF020) and address bit 2 is 1, that is, at 0xF024 by default. A read anywhere else returns 0, and a write anywhere else changes nothing.
- R9: The reset counter saturates at its maximum value and never wraps back to zero.
- R10: When a reset event and a register write fall in the same cycle, the event wins. The write has no effect on the word, the counter or `rst_req_o`.
- R11: While `rst_n` is low, the word is 0, `rst_req_o` is 0 and the counter is zero. The first reset event after that loads 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sys_rst_evt_i | input | 1 | One-cycle pulse for each system reset seen |
| acc_en_i | input | 1 | Access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data; 0 unless this is a read that hits the register |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `CNT_W` = 2, so the counter saturates after three reset events. That makes the saturation case reachable in a few cycles. A run of six events after the word has been cleared then tells a saturating counter apart from a wrapping one, because a wrap would reload 0x80000000. The default address width and base are kept, so that the miss cases cover both address bit 2 clear and neighbouring 8-byte slots.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BIT_POR      = 31;
  localparam int unsigned BIT_SOFT_POR = 30;
  localparam int unsigned BIT_SOFT_EXT = 29;
  localparam int unsigned BIT_BTN_POR  = 28;
  localparam int unsigned BIT_BTN_EXT  = 27;
  localparam logic [WORD_W-1:0] IMPL_MASK = 32'hF800_0000;
  localparam logic [WORD_W-1:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [WORD_W-1:0] WSET_MASK = 32'h6000_0000;
  localparam logic [WORD_W-1:0] POR_ONLY  = 32'h8000_0000;
endpackage

// File: rtl/rcr_addr_dec.sv
module rcr_addr_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned SLOT_LSB = 3;
  localparam logic [ADDR_W-1:SLOT_LSB] SLOT = BASE[ADDR_W-1:SLOT_LSB];

  always_comb begin
    hit_o = (addr_i[ADDR_W-1:SLOT_LSB] == SLOT) && addr_i[2];
  end
endmodule

// File: rtl/rcr_boot_cnt.sv
module rcr_boot_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
    end
  end

  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/rcr_cause_reg.sv
module rcr_cause_reg
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              first_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] cause_o,
  output logic              req_o
);
  logic [WORD_W-1:0] wv;
  logic [WORD_W-1:0] cause_q;
  logic              req_q;

  assign wv = wdata_i & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      req_q   <= 1'b0;
    end else if (evt_i) begin
      if (first_i) cause_q <= POR_ONLY;
      req_q <= 1'b0;
    end else if (wr_i) begin
      cause_q <= (cause_q & ~(wv & W1C_MASK)) | (wv & WSET_MASK);
      req_q   <= |(wv & WSET_MASK);
    end else begin
      req_q <= 1'b0;
    end
  end

  assign cause_o = cause_q;
  assign req_o   = req_q;
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_evt_i,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [31:0]       acc_wdata_i,
  output logic [31:0]       acc_rdata_o,
  output logic              rst_req_o
);
  logic              hit;
  logic              wr_hit;
  logic              boot_first;
  logic [WORD_W-1:0] cause_q;

  rcr_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr_i (acc_addr_i),
    .hit_o  (hit)
  );

  assign wr_hit = acc_en_i & acc_wr_i & hit;

  rcr_boot_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (sys_rst_evt_i),
    .clr_i   (wr_hit & acc_wdata_i[BIT_SOFT_POR]),
    .first_o (boot_first)
  );

  rcr_cause_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (sys_rst_evt_i),
    .first_i (boot_first),
    .wr_i    (wr_hit),
    .wdata_i (acc_wdata_i),
    .cause_o (cause_q),
    .req_o   (rst_req_o)
  );

  assign acc_rdata_o = (acc_en_i && !acc_wr_i && hit) ? cause_q : '0;
endmodule

// File: rtl/rst_cause_ctl_chk.sv
module rst_cause_ctl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_evt_i,
  input logic              acc_en_i,
  input logic              acc_wr_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [31:0]       acc_wdata_i,
  input logic [31:0]       acc_rdata_o,
  input logic              rst_req_o,
  input logic [31:0]       cause_q,
  input logic              boot_first
);
  logic sel;
  logic soft_wr;
  assign sel = ((acc_addr_i >> 3) == (BASE >> 3)) && acc_addr_i[2];
  assign soft_wr = acc_en_i && acc_wr_i && sel && (acc_wdata_i[30] || acc_wdata_i[29]);

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[26:0] == 27'd0); // R1
  AST_REQ_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_wr && !sys_rst_evt_i) |=> rst_req_o); // R4
  AST_REQ_ONLY_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(soft_wr && !sys_rst_evt_i) |=> !rst_req_o); // R4
  AST_SOFTPOR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && acc_wr_i && sel && acc_wdata_i[30] && !sys_rst_evt_i) |=> boot_first); // R5
  AST_POR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt_i && boot_first) |=> (cause_q == 32'h8000_0000)); // R6
  AST_LATER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt_i && !boot_first) |=> $stable(cause_q)); // R7
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en_i && !acc_wr_i && sel) |-> (acc_rdata_o == 32'd0)); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_evt_i) |=> !boot_first); // R9
endmodule

bind rst_cause_ctl rst_cause_ctl_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sys_rst_evt_i (sys_rst_evt_i),
  .acc_en_i      (acc_en_i),
  .acc_wr_i      (acc_wr_i),
  .acc_addr_i    (acc_addr_i),
  .acc_wdata_i   (acc_wdata_i),
  .acc_rdata_o   (acc_rdata_o),
  .rst_req_o     (rst_req_o),
  .cause_q       (cause_q),
  .boot_first    (boot_first)
);

// File: tb/tb_rst_cause_ctl.sv
module tb_rst_cause_ctl;
  localparam int unsigned ADDR_W = 16;
  localparam logic [15:0] REG_A = 16'hF024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic        en = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rst_cause_ctl #(.ADDR_W(ADDR_W), .BASE(16'hF020), .CNT_W(2)) dut (
    .clk (clk), .rst_n (rst_n), .sys_rst_evt_i (evt),
    .acc_en_i (en), .acc_wr_i (wr), .acc_addr_i (addr),
    .acc_wdata_i (wdata), .acc_rdata_o (rdata), .rst_req_o (req)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read, 2 reset event
    logic [15:0] addr;
    logic [31:0] data;
    logic        req;  // expected rst_req_o after the op
    logic [31:0] rd;   // expected read value afterwards
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd1, 16'hF024, 32'h0,          1'b0, 32'h0},          // R11 reset state
    '{2'd2, 16'hF024, 32'h0,          1'b0, 32'h8000_0000},  // R6 first event
    '{2'd2, 16'hF024, 32'h0,          1'b0, 32'h8000_0000},  // R7 later event
    '{2'd0, 16'hF024, 32'h8000_0000,  1'b0, 32'h0},          // R2 clear bit 31
    '{2'd0, 16'hF024, 32'h2000_0000,  1'b1, 32'h2000_0000},  // R3 R4 soft ext
    '{2'd2, 16'hF024, 32'h0,          1'b0, 32'h2000_0000},  // R7 R5 no re-arm
    '{2'd0, 16'hF024, 32'h4000_0000,  1'b1, 32'h6000_0000},  // R3 R4 soft por
    '{2'd2, 16'hF024, 32'h0,          1'b0, 32'h8000_0000},  // R5 re-armed
    '{2'd0, 16'hF024, 32'h07FF_FFFF,  1'b0, 32'h8000_0000},  // R1 unimpl bits
    '{2'd1, 16'hF020, 32'h0,          1'b0, 32'h0},          // R8 bit 2 clear
    '{2'd1, 16'hF02C, 32'h0,          1'b0, 32'h0},          // R8 next slot
    '{2'd0, 16'hF020, 32'h8000_0000,  1'b0, 32'h8000_0000}   // R8 write miss
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic with_evt);
    @(negedge clk);
    en = 1'b1; wr = 1'b1; addr = a; wdata = d; evt = with_evt;
    @(negedge clk);
    en = 1'b0; wr = 1'b0; evt = 1'b0;
  endtask

  task automatic do_evt();
    @(negedge clk);
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    en = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    en = 1'b0;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    chk("R11 req low in reset", {31'd0, req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [15:0] ra;
      ra = REG_A;
      case (VEC[i].op)
        2'd0: do_write(VEC[i].addr, VEC[i].data, 1'b0);
        2'd2: do_evt();
        default: begin @(negedge clk); ra = VEC[i].addr; end
      endcase
      chk($sformatf("R4 vec%0d req", i), {31'd0, req}, {31'd0, VEC[i].req});
      do_read(ra, rv);
      chk($sformatf("R8 vec%0d read", i), rv, VEC[i].rd);
      @(negedge clk);
      chk($sformatf("R4 vec%0d req one cycle", i), {31'd0, req}, 32'd0);
    end

    // R9: counter saturates (CNT_W=2): clear word, six events must not reload it
    do_write(REG_A, 32'h8000_0000, 1'b0);
    for (int k = 0; k < 6; k++) do_evt();
    do_read(REG_A, rv);
    chk("R9 saturate no reload", rv, 32'h0);

    // R10: event and soft write in the same cycle, event wins
    do_write(REG_A, 32'h6000_0000, 1'b1);
    chk("R10 collision req", {31'd0, req}, 32'd0);
    do_read(REG_A, rv);
    chk("R10 collision word", rv, 32'h0);
    do_evt();
    do_read(REG_A, rv);
    chk("R10 counter not cleared", rv, 32'h0);

    // R2: writing 0 leaves bit 31; button bits read 0 and stay 0 on clear
    do_write(REG_A, 32'h2000_0000, 1'b0);
    do_write(REG_A, 32'h1800_0000, 1'b0);
    do_read(REG_A, rv);
    chk("R2 button clear harmless", rv, 32'h2000_0000);

    // R11: power-on reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    do_read(REG_A, rv);
    chk("R11 word cleared", rv, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    do_evt();
    do_read(REG_A, rv);
    chk("R11 first event after por", rv, 32'h8000_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule